// File: doc/BRIEF.md
# Dual-Lane Registered Bus Transceiver

The block passes byte-wide data between two buses, called the A side and the B side, in any number of fully independent lanes (two by default). Each lane holds one storage register per direction. The A-to-B register captures the A bus and the B-to-A register captures the B bus. Every output port chooses between the live value on the opposite bus and the contents of that direction's storage register. Each bus pin appears as three separate signals: an input carrying the resolved bus value, an output value, and a per-bit output enable. The tri-state resolution therefore happens outside the block, and the block contains no internal tri-state logic.

Captures are triggered by per-lane strobe inputs. These are sampled by the system clock and act on their rising edge. A capture takes whatever value is on the bus at that moment, whatever the select and drive settings are. This is why the lane can copy one bus into both registers: when the A-to-B path drives the B bus live, a B-side capture stores A data. When both directions drive live, each bus is fed from the other side's input. An undriven pair of buses then keeps its last value through the loop outside the block.

A parameter chooses between rising-edge capture and plain level-enable capture. The default is rising-edge capture.

Top module: `xcvr_dual_reg`

## Requirements
- R1: The lanes are independent. A strobe, select or drive input of lane k changes only lane k's registers and outputs. Lane k occupies bits [k*LANE_W +: LANE_W] of each bus vector.
- R2: A rising edge of `a2b_strobe[k]` loads the A bus value present before the clock edge into lane k's A-to-B register. A rising edge of `b2a_strobe[k]` does the same from the B bus into the B-to-A register. A rising edge means the strobe was sampled low at one clock edge and high at the next. Loading happens whatever the select and drive inputs are.
- R3: Without a rising edge, a register keeps its value. This includes a strobe that is held high for several clock edges: only its first edge loads.
- R4: An active-low asynchronous reset `rst_n` clears every register to zero. It also records every strobe as previously high, so a strobe that is high when reset is released loads nothing.
- R5: `b_oe` for a lane is all ones when `b_drive_en` is 1 and all zeros when it is 0. `a_oe` is all ones when `a_drive_en_n` is 0 and all zeros when it is 1. With `b_drive_en`=0 and `a_drive_en_n`=1 the lane is isolated, and captures still work.
- R6: With `a2b_pick_reg`=0, `b_out` equals the live `a_in` in the same cycle. With `b2a_pick_reg`=0, `a_out` equals the live `b_in`.
- R7: With `a2b_pick_reg`=1, `b_out` equals the A-to-B register. With `b2a_pick_reg`=1, `a_out` equals the B-to-A register. Both stored paths can be active at once.
- R8: Captures see the resolved bus. While the B bus is driven live from A, a B-side capture stores A data. Strobing both sides then stores the same value in both registers.
- R9: With both drives on and both selects live, `a_out` equals `b_in` and `b_out` equals `a_in`. An undriven bus pair therefore holds its last value.
- R10: In the stored loop-back, both strobes rising on the same clock edge load the B-to-A register with the A-to-B register's previous contents and the A-to-B register with the A bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a2b_strobe | input | NUM_LANES | Per-lane capture strobe for the A-to-B register |
| b2a_strobe | input | NUM_LANES | Per-lane capture strobe for the B-to-A register |
| a2b_pick_reg | input | NUM_LANES | 1: B side outputs stored data; 0: live A data |
| b2a_pick_reg | input | NUM_LANES | 1: A side outputs stored data; 0: live B data |
| b_drive_en | input | NUM_LANES | Active-high drive enable for the B side |
| a_drive_en_n | input | NUM_LANES | Active-low drive enable for the A side |
| a_in | input | LANE_W*NUM_LANES | Resolved A bus value |
| b_in | input | LANE_W*NUM_LANES | Resolved B bus value |
| a_out | output | LANE_W*NUM_LANES | Value offered to the A bus |
| a_oe | output | LANE_W*NUM_LANES | Per-bit drive enable for the A bus |
| b_out | output | LANE_W*NUM_LANES | Value offered to the B bus |
| b_oe | output | LANE_W*NUM_LANES | Per-bit drive enable for the B bus |

## Verification
A register that captured the wrong value, or failed to capture, shows nothing at the ports until its direction selects stored data. From that cycle on, it appears on the opposite output combinationally. The bench therefore selects stored data often, and right after captures. A wrong live path or drive decode shows up in the same cycle as the control change. Loop-back faults such as a capture through the resolved bus or a simultaneous capture show up one clock edge later, once the affected register is selected.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

   typedef enum logic {
      SRC_LIVE = 1'b0,
      SRC_HELD = 1'b1
   } src_sel_e;

   typedef struct packed {
      logic cap_ab;
      logic cap_ba;
      logic pick_ab;
      logic pick_ba;
      logic drv_b;
      logic drv_a_n;
   } lane_ctl_t;

endpackage

// File: rtl/xcvr_strobe_det.sv
`timescale 1ns/1ps
module xcvr_strobe_det #(
   parameter int EDGE_MODE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic load
);

   generate
      if (EDGE_MODE != 0) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= strobe;
         end
         assign load = strobe & ~prev_q;
      end else begin : g_level
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign load = strobe;
      end
   endgenerate

endmodule

// File: rtl/xcvr_store_reg.sv
`timescale 1ns/1ps
module xcvr_store_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));  // R2
   AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));  // R3

endmodule

// File: rtl/xcvr_out_path.sv
`timescale 1ns/1ps
module xcvr_out_path
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   input  logic         pick_reg,
   input  logic         drive,
   output logic [W-1:0] out,
   output logic [W-1:0] oe
);

   src_sel_e src;
   assign src = src_sel_e'(pick_reg);

   always_comb begin
      unique case (src)
         SRC_HELD: out = stored;
         default:  out = live;
      endcase
   end

   assign oe = {W{drive}};

endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter int EDGE_MODE = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  lane_ctl_t    ctl,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe
);

   logic         load_ab, load_ba;
   logic [W-1:0] ab_q, ba_q;

   xcvr_strobe_det #(.EDGE_MODE(EDGE_MODE)) i_det_ab (
      .clk(clk), .rst_n(rst_n), .strobe(ctl.cap_ab), .load(load_ab));
   xcvr_strobe_det #(.EDGE_MODE(EDGE_MODE)) i_det_ba (
      .clk(clk), .rst_n(rst_n), .strobe(ctl.cap_ba), .load(load_ba));

   xcvr_store_reg #(.W(W)) i_reg_ab (
      .clk(clk), .rst_n(rst_n), .load(load_ab), .d(a_in), .q(ab_q));
   xcvr_store_reg #(.W(W)) i_reg_ba (
      .clk(clk), .rst_n(rst_n), .load(load_ba), .d(b_in), .q(ba_q));

   xcvr_out_path #(.W(W)) i_path_b (
      .live(a_in), .stored(ab_q), .pick_reg(ctl.pick_ab),
      .drive(ctl.drv_b), .out(b_out), .oe(b_oe));
   xcvr_out_path #(.W(W)) i_path_a (
      .live(b_in), .stored(ba_q), .pick_reg(ctl.pick_ba),
      .drive(~ctl.drv_a_n), .out(a_out), .oe(a_oe));

   AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.pick_ab |-> (b_out == a_in));  // R6
   AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.pick_ba |-> (a_out == b_in));  // R6
   AST_STORED_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.pick_ab |-> (b_out == ab_q));  // R7
   AST_STORED_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.pick_ba |-> (a_out == ba_q));  // R7

   generate
      if (EDGE_MODE != 0) begin : g_edge_chk
         AST_HIGH_STROBE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl.cap_ab && $past(ctl.cap_ab)) |=> $stable(ab_q));  // R3
      end
   endgenerate

endmodule

// File: rtl/xcvr_dual_reg.sv
`timescale 1ns/1ps
module xcvr_dual_reg
   import xcvr_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int NUM_LANES = 2,
   parameter int EDGE_MODE = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_LANES-1:0]          a2b_strobe,
   input  logic [NUM_LANES-1:0]          b2a_strobe,
   input  logic [NUM_LANES-1:0]          a2b_pick_reg,
   input  logic [NUM_LANES-1:0]          b2a_pick_reg,
   input  logic [NUM_LANES-1:0]          b_drive_en,
   input  logic [NUM_LANES-1:0]          a_drive_en_n,
   input  logic [LANE_W*NUM_LANES-1:0]   a_in,
   input  logic [LANE_W*NUM_LANES-1:0]   b_in,
   output logic [LANE_W*NUM_LANES-1:0]   a_out,
   output logic [LANE_W*NUM_LANES-1:0]   a_oe,
   output logic [LANE_W*NUM_LANES-1:0]   b_out,
   output logic [LANE_W*NUM_LANES-1:0]   b_oe
);

   localparam int BUS_W = LANE_W * NUM_LANES;

   generate
      if (LANE_W < 1) begin : g_bad_width
         $error("xcvr_dual_reg: LANE_W must be at least 1");
      end
      if (NUM_LANES < 1) begin : g_bad_lanes
         $error("xcvr_dual_reg: NUM_LANES must be at least 1");
      end
      if (EDGE_MODE != 0 && EDGE_MODE != 1) begin : g_bad_mode
         $error("xcvr_dual_reg: EDGE_MODE must be 0 or 1");
      end
      if (BUS_W < 1) begin : g_bad_bus
         $error("xcvr_dual_reg: empty bus");
      end
   endgenerate

   generate
      for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
         lane_ctl_t ctl;
         assign ctl.cap_ab  = a2b_strobe[k];
         assign ctl.cap_ba  = b2a_strobe[k];
         assign ctl.pick_ab = a2b_pick_reg[k];
         assign ctl.pick_ba = b2a_pick_reg[k];
         assign ctl.drv_b   = b_drive_en[k];
         assign ctl.drv_a_n = a_drive_en_n[k];

         xcvr_lane #(.W(LANE_W), .EDGE_MODE(EDGE_MODE)) i_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl),
            .a_in  (a_in [k*LANE_W +: LANE_W]),
            .b_in  (b_in [k*LANE_W +: LANE_W]),
            .a_out (a_out[k*LANE_W +: LANE_W]),
            .a_oe  (a_oe [k*LANE_W +: LANE_W]),
            .b_out (b_out[k*LANE_W +: LANE_W]),
            .b_oe  (b_oe [k*LANE_W +: LANE_W])
         );
      end
   endgenerate

endmodule

// File: tb/test_xcvr_dual_reg.sv
`timescale 1ns/1ps
module test_xcvr_dual_reg;

   localparam int W  = 8;
   localparam int N  = 2;
   localparam int BW = W * N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] cab = '0, cba = '0, sab = '0, sba = '0, db = '0, dan = '1;
   logic [BW-1:0] bus_a = '0, bus_b = '0;
   logic [BW-1:0] a_out, a_oe, b_out, b_oe;

   logic [N-1:0]  ext_a_en = '0, ext_b_en = '0;
   logic [BW-1:0] ext_a = '0, ext_b = '0, held_a = '0, held_b = '0;
   logic [BW-1:0] m_areg = '0, m_breg = '0, m_held_a = '0, m_held_b = '0;
   logic [BW-1:0] m_bus_a = '0, m_bus_b = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   xcvr_dual_reg #(.LANE_W(W), .NUM_LANES(N)) i_xcvr_dual_reg (
      .clk(clk), .rst_n(rst_n),
      .a2b_strobe(cab), .b2a_strobe(cba),
      .a2b_pick_reg(sab), .b2a_pick_reg(sba),
      .b_drive_en(db), .a_drive_en_n(dan),
      .a_in(bus_a), .b_in(bus_b),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

   task automatic chk(input string tag, input int l, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s lane %0d %s: got %h expected %h", tag, l, what, act, exp);
      end
   endtask

   // resolve both buses outside the design: chip drive first, then external, else hold
   task automatic settle();
      for (int it = 0; it < 3; it++) begin
         #1;
         for (int l = 0; l < N; l++) begin
            logic [W-1:0] na, nb;
            na = a_oe[l*W] ? a_out[l*W +: W]
               : (ext_a_en[l] ? ext_a[l*W +: W] : held_a[l*W +: W]);
            nb = b_oe[l*W] ? b_out[l*W +: W]
               : (ext_b_en[l] ? ext_b[l*W +: W] : held_b[l*W +: W]);
            bus_a[l*W +: W] = na;
            bus_b[l*W +: W] = nb;
         end
      end
      #1;
      held_a = bus_a;
      held_b = bus_b;
   endtask

   task automatic model_lane(input int l, output logic [W-1:0] ea, output logic [W-1:0] eb);
      logic da, dbb;
      logic [W-1:0] xa, xb, ra, rb;
      da  = !dan[l];
      dbb = db[l];
      ra  = m_areg[l*W +: W];
      rb  = m_breg[l*W +: W];
      xa  = ext_a_en[l] ? ext_a[l*W +: W] : m_held_a[l*W +: W];
      xb  = ext_b_en[l] ? ext_b[l*W +: W] : m_held_b[l*W +: W];
      if (!da && !dbb) begin
         ea = xa; eb = xb;
      end else if (da && !dbb) begin
         eb = xb; ea = sba[l] ? rb : eb;
      end else if (!da && dbb) begin
         ea = xa; eb = sab[l] ? ra : ea;
      end else if (sab[l] && sba[l]) begin
         ea = rb; eb = ra;
      end else if (sab[l]) begin
         eb = ra; ea = eb;
      end else if (sba[l]) begin
         ea = rb; eb = ea;
      end else begin
         ea = m_held_a[l*W +: W]; eb = ea;   // R9 loop keeps last value
      end
   endtask

   task automatic check_all(input string tag);
      for (int l = 0; l < N; l++) begin
         logic [W-1:0] ea, eb, eao, ebo;
         model_lane(l, ea, eb);
         eao = sba[l] ? m_breg[l*W +: W] : eb;
         ebo = sab[l] ? m_areg[l*W +: W] : ea;
         chk(tag, l, "A bus", bus_a[l*W +: W], ea);
         chk(tag, l, "B bus", bus_b[l*W +: W], eb);
         chk(sba[l] ? "R7" : "R6", l, "a_out", a_out[l*W +: W], eao);
         chk(sab[l] ? "R7" : "R6", l, "b_out", b_out[l*W +: W], ebo);
         chk("R5", l, "a_oe", a_oe[l*W +: W], {W{!dan[l]}});
         chk("R5", l, "b_oe", b_oe[l*W +: W], {W{db[l]}});
         m_bus_a[l*W +: W]  = ea;
         m_bus_b[l*W +: W]  = eb;
         m_held_a[l*W +: W] = ea;
         m_held_b[l*W +: W] = eb;
      end
   endtask

   task automatic step(input string tag);
      settle();
      check_all(tag);
   endtask

   // one-edge strobe pulse followed by an idle edge so the next pulse is a fresh rise (R2)
   task automatic pulse(input logic [N-1:0] pa, input logic [N-1:0] pb);
      cab = pa;
      cba = pb;
      @(posedge clk);
      #1;
      cab = '0;
      cba = '0;
      for (int l = 0; l < N; l++) begin
         if (pa[l]) m_areg[l*W +: W] = m_bus_a[l*W +: W];
         if (pb[l]) m_breg[l*W +: W] = m_bus_b[l*W +: W];
      end
      @(posedge clk);
      #1;
   endtask

   task automatic set_ctl(input int l, input logic b_en, input logic a_en_n,
                          input logic p_ab, input logic p_ba);
      db[l] = b_en; dan[l] = a_en_n; sab[l] = p_ab; sba[l] = p_ba;
   endtask

   task automatic set_ext(input int l, input logic ae, input logic [W-1:0] av,
                          input logic be, input logic [W-1:0] bv);
      ext_a_en[l] = ae; ext_a[l*W +: W] = av;
      ext_b_en[l] = be; ext_b[l*W +: W] = bv;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R4: strobes high across reset release must not load
      cab = '1; cba = '1;
      set_ext(0, 1'b1, 8'hAA, 1'b1, 8'h55);
      set_ext(1, 1'b1, 8'h0F, 1'b1, 8'hF0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1 cab = '0; cba = '0;
      @(posedge clk);
      #1;
      for (int l = 0; l < N; l++) set_ctl(l, 1'b1, 1'b0, 1'b1, 1'b1);
      for (int l = 0; l < N; l++) set_ext(l, 1'b0, 8'h00, 1'b0, 8'h00);
      step("R4");

      // R1: load lane 1 only, then leave it alone while lane 0 is worked
      for (int l = 0; l < N; l++) set_ctl(l, 1'b0, 1'b1, 1'b0, 1'b0);
      set_ext(1, 1'b1, 8'h77, 1'b1, 8'h66);
      step("R1");
      pulse(2'b10, 2'b10);

      // R3: strobe held high across two edges loads only on the first
      set_ext(0, 1'b1, 8'h5A, 1'b0, 8'h00);
      set_ext(1, 1'b1, 8'h99, 1'b1, 8'h88);
      step("R3");
      cab[0] = 1'b1;
      @(posedge clk);
      #1;
      m_areg[0 +: W] = m_bus_a[0 +: W];
      set_ext(0, 1'b1, 8'h33, 1'b0, 8'h00);
      step("R3");
      @(posedge clk);
      #1 cab[0] = 1'b0;
      @(posedge clk);
      #1;
      set_ctl(0, 1'b1, 1'b1, 1'b1, 1'b0);
      set_ctl(1, 1'b1, 1'b0, 1'b1, 1'b1);
      step("R3");
      step("R1");

      // R8: B driven live from A, B-side capture stores A data
      set_ctl(0, 1'b1, 1'b1, 1'b0, 1'b0);
      set_ext(0, 1'b1, 8'h3C, 1'b0, 8'h00);
      set_ctl(1, 1'b0, 1'b1, 1'b0, 1'b0);
      step("R8");
      pulse(2'b00, 2'b01);
      set_ctl(0, 1'b0, 1'b0, 1'b0, 1'b1);
      set_ext(0, 1'b0, 8'h00, 1'b0, 8'h00);
      step("R8");

      // R9: both drives live, no external source: bus pair holds
      set_ctl(1, 1'b1, 1'b1, 1'b0, 1'b0);
      set_ext(1, 1'b1, 8'hC3, 1'b0, 8'h00);
      step("R9");
      set_ctl(1, 1'b1, 1'b0, 1'b0, 1'b0);
      set_ext(1, 1'b0, 8'h00, 1'b0, 8'h00);
      step("R9");
      step("R9");
      pulse(2'b10, 2'b10);
      set_ctl(1, 1'b1, 1'b0, 1'b1, 1'b1);
      step("R8");

      // R10: stored loop-back, both strobes on one edge
      set_ctl(0, 1'b0, 1'b1, 1'b0, 1'b0);
      set_ext(0, 1'b1, 8'h11, 1'b0, 8'h00);
      step("R10");
      pulse(2'b01, 2'b00);
      set_ctl(0, 1'b1, 1'b1, 1'b1, 1'b0);
      set_ext(0, 1'b1, 8'h22, 1'b0, 8'h00);
      step("R10");
      pulse(2'b01, 2'b01);
      set_ctl(0, 1'b1, 1'b0, 1'b1, 1'b1);
      step("R10");

      // R2: random control rows, bus values and strobes
      for (int it = 0; it < 400; it++) begin
         for (int l = 0; l < N; l++) begin
            logic [31:0] r;
            r = $urandom;
            set_ctl(l, r[0], r[1], r[2], r[3]);
            if (r[0] && !r[1] && !r[2] && !r[3]) sab[l] = 1'b1;
            set_ext(l, r[4], r[15:8], r[5], r[23:16]);
         end
         step("R2");
         begin
            logic [31:0] s;
            s = $urandom;
            pulse(s[N-1:0], s[N+7:8]);
         end
      end
      step("R2");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule